// File: doc/BRIEF.md
# SPI EEPROM Slave Controller

This block is the slave side of a small serial EEPROM on an SPI bus that samples on the rising serial clock edge. It runs on a fast system clock and oversamples the serial clock, chip select, hold and write-protect pins. It decodes a command byte, collects a 10-bit byte address and data bytes, and serves reads from a 1 KiB byte array. The array is organised as 64 pages of 16 bytes.

Writes do not reach the array directly. They land in a 16-byte page buffer. When chip select rises on a byte boundary, a self-timed busy period of `PROG_CYCLES` system clocks starts. At its end the buffered bytes are committed to the array.

A status register reports the busy flag, a write-enable latch and a two-bit block-protect field. A hold input pauses the transfer mid-byte, and a write-protect input blocks all writes.

Top module: `spi_eeprom_slave`

## Requirements
- R1: `sdi` is sampled on each rising edge of `sck`. `sdo` changes only after a falling edge of `sck`, most significant bit first. The first bit of a reply appears after the falling edge that follows the last bit of the command or address.
- R2: A falling `cs_n` selects the device and a rising `cs_n` deselects it, but only when `sck` is low. A `cs_n` transition while `sck` is high is ignored, and the selection state stays as it was.
- R3: When the device is deselected, `sdo_oe` goes low at once.
- R4: After reset the device is deselected, `sdo_oe` is low, and the status register reads 0x00.
- R5: The address phase is two bytes. The low 2 bits of the first byte are address bits 9:8, and the second byte is bits 7:0. Write data bytes fill the page buffer at the column given by address bits 3:0. The column wraps modulo 16 and stays within the page.
- R6: While `hold_n` is low, `sck` edges are ignored, `sdo` is frozen and `sdo_oe` is low. When `hold_n` returns high, the transfer resumes at the same bit.
- R7: The status byte is {4'b0, bp[1:0], wel, wip}, with wip at bit 0.
  - Command 0x06 sets wel and command 0x04 clears it.
  - Command 0x05 streams the live status byte repeatedly.
  - Command 0x01 takes one data byte. Its bits 3:2 go into bp and wel is cleared, but only if wel is set and `wp_n` is high.
- R8: A page write is dropped when any of these holds: wel is clear, `wp_n` is low, or the page lies in the range that bp protects. The ranges are: bp=1 protects 0x300–0x3FF, bp=2 protects 0x200–0x3FF, and bp=3 protects the whole array.
- R9: Programming starts only when `cs_n` rises with no partial byte pending, after a write command (0x02) with at least one data byte. While programming, wip reads 1 for `PROG_CYCLES` system clocks. At the end, the buffered bytes are committed and wel clears. A write aborted mid-byte changes nothing.
- R10: A read (0x03) returns consecutive bytes and auto-increments across the whole array, wrapping from 0x3FF to 0x000.
- R11: While wip is set, every command except 0x05 is ignored. It drives no output and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low hold |
| wp_n | input | 1 | Active-low write protect |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (tri-state control) |

## Verification
The assertions check these properties on every cycle:
- selection never changes while `sck` is high;
- `sdo_oe` drops right after a valid deselect;
- `sdo` stays still while hold is asserted;
- a busy period starts only from a valid deselect with write protect released and wel set;
- wel is always clear when the busy period ends.

Only the bench's scenarios can show the rest:
- the data path: the bytes read back after page writes with a column wrap;
- the array-end wrap of a read;
- that protected or aborted writes leave the stored contents and status unchanged;
- that commands issued during the busy period are ignored.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic sdi,
  input  logic cs_n,
  input  logic hold_n,
  input  logic wp_n,
  output logic sdo,
  output logic sdo_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {P_CMD, P_AH, P_AL, P_RD, P_WR, P_RDSR, P_WRSR, P_IGN} phase_t;

  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pmask;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-PAGE_W-1:0] wpage;
  logic [CW-1:0] tmr;
  logic [6:0] sh;
  logic [7:0] tx;
  logic [2:0] bit_cnt;
  logic [1:0] bp;
  logic sck_q, cs_q, sel, oe_q, sdo_q, wip, wel, rd_cmd;
  phase_t ph;

  wire active   = sel & hold_n;
  wire rise     = active & sck & ~sck_q;
  wire fall     = active & ~sck & sck_q;
  wire cs_fall  = cs_q & ~cs_n & ~sck;
  wire cs_rise  = ~cs_q & cs_n & ~sck;
  wire byte_done = rise & (bit_cnt == 3'd7);
  wire [7:0] rx = {sh, sdi};
  wire [7:0] status = {4'b0, bp, wel, wip};
  wire prot = (bp == 2'd3) | ((bp == 2'd2) & addr[ADDR_W-1]) |
              ((bp == 2'd1) & (&addr[ADDR_W-1:ADDR_W-2]));
  wire go = cs_rise & sel & (ph == P_WR) & (bit_cnt == 3'd0) & (|pmask) &
            wel & wp_n & ~prot & ~wip;
  wire [ADDR_W-1:0] al_addr = {addr[ADDR_W-1:8], rx};

  assign sdo    = sdo_q;
  assign sdo_oe = sel & hold_n & oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; sel <= 1'b0; oe_q <= 1'b0; sdo_q <= 1'b0;
      bit_cnt <= '0; sh <= '0; tx <= '0; ph <= P_CMD; rd_cmd <= 1'b0;
      addr <= '0; wpage <= '0; pmask <= '0; wip <= 1'b0; wel <= 1'b0;
      bp <= '0; tmr <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_fall) begin
        sel <= 1'b1; ph <= P_CMD; bit_cnt <= '0; oe_q <= 1'b0;
      end else if (cs_rise) begin
        sel <= 1'b0; oe_q <= 1'b0;
        if (go) begin
          wip <= 1'b1; tmr <= CW'(PROG_CYCLES); wpage <= addr[ADDR_W-1:PAGE_W];
        end
      end else begin
        if (rise) begin
          sh <= rx[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (fall) begin
          sdo_q <= tx[~bit_cnt];
          if (ph == P_RD || ph == P_RDSR) oe_q <= 1'b1;
        end
        if (byte_done) begin
          case (ph)
            P_CMD:
              if (wip && rx != 8'h05) ph <= P_IGN;
              else case (rx)
                8'h06: begin wel <= 1'b1; ph <= P_IGN; end
                8'h04: begin wel <= 1'b0; ph <= P_IGN; end
                8'h05: begin tx <= status; ph <= P_RDSR; end
                8'h01: ph <= P_WRSR;
                8'h03: begin rd_cmd <= 1'b1; ph <= P_AH; end
                8'h02: begin rd_cmd <= 1'b0; pmask <= '0; ph <= P_AH; end
                default: ph <= P_IGN;
              endcase
            P_AH: begin addr[ADDR_W-1:8] <= rx[ADDR_W-9:0]; ph <= P_AL; end
            P_AL: begin
              addr <= al_addr + ADDR_W'(rd_cmd);
              if (rd_cmd) begin tx <= mem[al_addr]; ph <= P_RD; end
              else ph <= P_WR;
            end
            P_RD: begin tx <= mem[addr]; addr <= addr + 1'b1; end
            P_RDSR: tx <= status;
            P_WRSR: begin
              if (wel && wp_n) begin bp <= rx[3:2]; wel <= 1'b0; end
              ph <= P_IGN;
            end
            P_WR: begin
              pmask[addr[PAGE_W-1:0]] <= 1'b1;
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (wip) begin
        tmr <= tmr - 1'b1;
        if (tmr == CW'(1)) begin wip <= 1'b0; wel <= 1'b0; pmask <= '0; end
      end
    end
  end

  always_ff @(posedge clk)
    if (byte_done && ph == P_WR) pbuf[addr[PAGE_W-1:0]] <= rx;

  always_ff @(posedge clk)
    if (wip && tmr == CW'(1))
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{wpage, PAGE_W'(i)}] <= pbuf[i];

  p_cs_ignored_sck_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> $stable(sel));
  p_hiz_on_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && !sck) |=> !sdo_oe);
  p_hold_freezes_sdo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> $stable(sdo));
  p_prog_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wp_n && wel));
  p_prog_on_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_n && !sck));
  p_wel_clear_after_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
endmodule

// File: tb/sim_spi_eeprom_slave.sv
module sim_spi_eeprom_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_eeprom_slave #(.PROG_CYCLES(300)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_n(cs_n),
    .hold_n(hold_n), .wp_n(wp_n), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, input int nbits, input int hold_bit,
                      output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = d[i];
      wait_clks(4);
      if (i == hold_bit) begin
        hold_n = 1'b0;
        wait_clks(3);
        chk("R6 oe low in hold", {7'b0, sdo_oe}, 8'h00);
        wait_clks(3);
        hold_n = 1'b1;
        wait_clks(2);
      end
      r[i] = sdo;
      sck = 1'b1;
      wait_clks(4);
      sck = 1'b0;
    end
  endtask

  task automatic sel_on();  cs_n = 1'b0; wait_clks(4); endtask
  task automatic sel_off(); wait_clks(4); cs_n = 1'b1; wait_clks(4); endtask

  task automatic send(input logic [7:0] d);
    logic [7:0] r;
    xfer(d, 8, -1, r);
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] exp, input int hold_bit);
    logic [7:0] r;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(8'h00, 8, hold_bit, r);
    got_q.push_back(r);
  endtask

  task automatic cmd1(input logic [7:0] c);
    sel_on(); send(c); sel_off();
  endtask

  task automatic expect_status(input string tag, input logic [7:0] exp);
    sel_on(); send(8'h05); expect_byte(tag, exp, -1); sel_off();
  endtask

  task automatic wait_ready();
    logic [7:0] r;
    r = 8'h01;
    while (r[0]) begin
      sel_on(); send(8'h05); xfer(8'h00, 8, -1, r); sel_off();
    end
  endtask

  task automatic page_write(input logic [9:0] a, input logic [7:0] d0, input int n);
    sel_on(); send(8'h02); send({6'b0, a[9:8]}); send(a[7:0]);
    for (int k = 0; k < n; k++) send(d0 + 8'(k));
    sel_off();
  endtask

  task automatic write_byte(input logic [9:0] a, input logic [7:0] d);
    cmd1(8'h06); page_write(a, d, 1); wait_ready();
  endtask

  task automatic read_start(input logic [9:0] a);
    sel_on(); send(8'h03); send({6'b0, a[9:8]}); send(a[7:0]);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        automatic logic [7:0] g = got_q.pop_front();
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, g, e);
      end
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [7:0] r;
    wait_clks(6);
    rst_n = 1'b1;
    wait_clks(4);
    chk("R4 oe after reset", {7'b0, sdo_oe}, 8'h00);
    expect_status("R4 status after reset", 8'h00);

    page_write(10'h010, 8'h55, 1);
    expect_status("R8 write without wel dropped", 8'h00);

    cmd1(8'h06);
    expect_status("R7 wren sets wel", 8'h02);
    cmd1(8'h04);
    expect_status("R7 wrdi clears wel", 8'h00);
    cmd1(8'h06);

    page_write(10'h01E, 8'hA1, 3);
    expect_status("R9 busy with wel", 8'h03);
    read_start(10'h01E);
    xfer(8'h00, 8, -1, r);
    chk("R11 read ignored while busy", {7'b0, sdo_oe}, 8'h00);
    sel_off();
    sel_on(); send(8'h01); send(8'h0C); sel_off();
    wait_ready();
    expect_status("R11 R9 wrsr ignored, wel cleared", 8'h00);

    read_start(10'h01E);
    expect_byte("R1 R5 byte at 0x01E", 8'hA1, -1);
    expect_byte("R5 byte at 0x01F", 8'hA2, -1);
    sel_off();
    read_start(10'h010);
    expect_byte("R5 column wrap to 0x010", 8'hA3, -1);
    sel_off();

    write_byte(10'h3FF, 8'h5A);
    write_byte(10'h000, 8'hC3);
    read_start(10'h3FF);
    expect_byte("R10 byte at 0x3FF", 8'h5A, -1);
    expect_byte("R10 wrap to 0x000", 8'hC3, -1);
    sel_off();

    write_byte(10'h100, 8'h22);
    wp_n = 1'b0;
    cmd1(8'h06);
    page_write(10'h100, 8'h11, 1);
    expect_status("R8 write blocked by wp", 8'h02);
    sel_on(); send(8'h01); send(8'h0C); sel_off();
    expect_status("R7 wrsr blocked by wp", 8'h02);
    wp_n = 1'b1;
    read_start(10'h100);
    expect_byte("R8 data kept under wp", 8'h22, -1);
    sel_off();

    sel_on(); send(8'h01); send(8'h04); sel_off();
    expect_status("R7 wrsr sets bp", 8'h04);
    cmd1(8'h06);
    page_write(10'h300, 8'h77, 1);
    expect_status("R8 upper quarter protected", 8'h06);
    page_write(10'h100, 8'h33, 1);
    wait_ready();
    read_start(10'h100);
    expect_byte("R8 unprotected page written", 8'h33, -1);
    sel_off();
    cmd1(8'h06);
    sel_on(); send(8'h01); send(8'h00); sel_off();

    read_start(10'h01E);
    expect_byte("R6 byte across hold", 8'hA1, 4);
    wait_clks(2);
    cs_n = 1'b1;
    wait_clks(2);
    chk("R3 oe low after deselect", {7'b0, sdo_oe}, 8'h00);
    wait_clks(4);

    sck = 1'b1; wait_clks(3);
    cs_n = 1'b0; wait_clks(3);
    sck = 1'b0; wait_clks(4);
    send(8'h05);
    xfer(8'h00, 8, -1, r);
    chk("R2 select while sck high ignored", {7'b0, sdo_oe}, 8'h00);
    sel_off();
    expect_status("R2 normal select works", 8'h00);

    cmd1(8'h06);
    sel_on(); send(8'h02); send(8'h00); send(8'h50); send(8'h99);
    xfer(8'hF0, 4, -1, r);
    sel_off();
    expect_status("R9 aborted write no busy", 8'h02);

    wait_clks(10);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule